// File: doc/BRIEF.md
# Index-Register Memory Transfer Unit

This block carries out the four instructions that move bytes between the sixteen 8-bit general registers and a 4096-byte memory through a 12-bit index register, I. The block owns I. It reads and writes the register file through a combinational read port and a separate write port. It reaches memory through one single-port interface that allows one access per cycle. A memory read returns its data on the cycle after the address is presented.

A host raises `start` for one cycle while the block is idle and supplies the low twelve instruction bits. Bits 7..0 select the operation and bits 11..8 give the register number x. The four operations are:

- Add Vx to I and report the carry in register F.
- Split Vx into three decimal digits and store them.
- Spill V0..Vx to memory.
- Fill V0..Vx from memory.

`done` is high during the final cycle of each operation. A host may also load I directly while the block is idle.

Top module: `idx_xfer_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `mem_we`, `mem_re` and `rf_we` are low and `idx_out` is 0; while idle, no memory or register access is made.
- R2: An operation is decoded from `instr[7:0]`, and x is taken from `instr[11:8]`. 0x1E selects add, 0x33 selects digit store, 0x55 selects block store and 0x65 selects block load.
- R3: Add (0x1E) completes in one cycle with `done`. I becomes (I + Vx) mod 4096. Register 15 is written with 1 when I + Vx is greater than 0xFFF, and with 0 otherwise. The old Vx is used even when x is 15.
- R4: Digit store (0x33) reads Vx in one cycle. It then writes the hundreds digit to I, the tens digit to I+1 and the ones digit to I+2, on three consecutive cycles. `done` is high on the third write, so the operation takes four cycles.
- R5: Block store (0x55) writes V0..Vx to I..I+x in ascending order, one byte per cycle. It finishes in x+1 cycles, with `done` on the last write. A read and a write never share a cycle.
- R6: Block load (0x65) issues reads of I..I+x on x+1 consecutive cycles. Each returned byte is written to V0..Vx in order on the following cycle. `done` is high on the last register write, in cycle x+2.
- R7: Digit store, block store and block load leave I unchanged. I never changes while an operation is in progress.
- R8: Every memory address used is computed modulo 4096, so a transfer that runs past 0xFFF continues at 0x000.
- R9: Any other operation code completes in one cycle, with `done` and `illegal` both high. It makes no memory or register access and leaves I unchanged.
- R10: `start` and `idx_set` are ignored while `busy` is high. After `done`, the block returns to idle on the next cycle.
- R11: When idle, `idx_set` loads `idx_set_val` into I on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (accepted only when idle) |
| instr | input | 12 | bits 11..8 register x, bits 7..0 operation code |
| idx_set | input | 1 | Load I directly (idle only) |
| idx_set_val | input | 12 | Value loaded into I |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Final cycle of the operation |
| illegal | output | 1 | Unsupported operation code (with done) |
| idx_out | output | 12 | Current value of I |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| mem_addr | output | 12 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |

## Verification
The assertions check five properties on every cycle:

- The block is silent while idle.
- An unsupported code completes with no access.
- A read and a write never share the memory port.
- I stays constant while an operation runs, and a direct load of I lands on the next edge.
- Every `done` is followed by idle.

Only the bench's scenarios can show the data that is moved:

- the decimal digits of 0, 109 and 255;
- the ascending address and data order of spills and fills, including runs that wrap past 0xFFF;
- the carry written to register 15, including when x is 15;
- the exact cycle count of each operation.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam logic [7:0] OPC_ADD_IDX = 8'h1E;
  localparam logic [7:0] OPC_DIGITS  = 8'h33;
  localparam logic [7:0] OPC_SPILL   = 8'h55;
  localparam logic [7:0] OPC_FILL    = 8'h65;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADD,
    SQ_DIG_RD,
    SQ_DIG_WR,
    SQ_SPILL,
    SQ_FILL,
    SQ_FILL_TAIL,
    SQ_BAD
  } sq_state_e;
endpackage

// File: rtl/ixu_digits.sv
// Splits an 8-bit value into hundreds, tens and ones by compare-and-subtract.
module ixu_digits (
  input  logic [7:0] val,
  output logic [3:0] hund,
  output logic [3:0] tens,
  output logic [3:0] ones
);
  logic [7:0] rem_h;
  logic [7:0] sub_t;

  always_comb begin
    if (val >= 8'd200) begin
      hund  = 4'd2;
      rem_h = val - 8'd200;
    end else if (val >= 8'd100) begin
      hund  = 4'd1;
      rem_h = val - 8'd100;
    end else begin
      hund  = 4'd0;
      rem_h = val;
    end
  end

  always_comb begin
    tens  = 4'd0;
    sub_t = 8'd0;
    for (int k = 1; k < 10; k++) begin
      if (rem_h >= 8'(10 * k)) begin
        tens  = 4'(k);
        sub_t = 8'(10 * k);
      end
    end
    ones = 4'(rem_h - sub_t);
  end
endmodule

// File: rtl/ixu_index_reg.sv
// Holds I; supports direct load and add-with-carry-out.
module ixu_index_reg #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_val,
  input  logic              add_en,
  input  logic [DATA_W-1:0] add_val,
  output logic [ADDR_W-1:0] idx,
  output logic              carry
);
  localparam int unsigned PAD_W = ADDR_W + 1 - DATA_W;

  logic [ADDR_W:0]   sum;
  logic [ADDR_W-1:0] idx_d;
  logic [ADDR_W-1:0] idx_q;
  logic              idx_en;

  assign sum   = {1'b0, idx_q} + {{PAD_W{1'b0}}, add_val};
  assign carry = sum[ADDR_W];

  always_comb begin
    idx_en = add_en | set_en;
    idx_d  = idx_q;
    if (add_en) begin
      idx_d = sum[ADDR_W-1:0];
    end else if (set_en) begin
      idx_d = set_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/ixu_seq.sv
// Operation sequencer: decode, step counter, done/illegal generation.
module ixu_seq
  import ixu_pkg::*;
#(
  parameter int unsigned RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opc,
  input  logic [RIDX_W-1:0] xin,
  output sq_state_e         state,
  output logic [RIDX_W-1:0] step,
  output logic [RIDX_W-1:0] xreg,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  localparam logic [RIDX_W-1:0] STEP_ONE  = RIDX_W'(1);
  localparam logic [RIDX_W-1:0] DIG_LAST  = RIDX_W'(2);

  sq_state_e         st_q, st_d;
  logic [RIDX_W-1:0] step_q, step_d;
  logic [RIDX_W-1:0] x_q;
  logic              accept;
  logic              last_step;

  assign accept    = start && (st_q == SQ_IDLE);
  assign last_step = (step_q == x_q);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      SQ_IDLE: begin
        step_d = '0;
        if (start) begin
          unique case (opc)
            OPC_ADD_IDX: st_d = SQ_ADD;
            OPC_DIGITS:  st_d = SQ_DIG_RD;
            OPC_SPILL:   st_d = SQ_SPILL;
            OPC_FILL:    st_d = SQ_FILL;
            default:     st_d = SQ_BAD;
          endcase
        end
      end
      SQ_ADD:    st_d = SQ_IDLE;
      SQ_BAD:    st_d = SQ_IDLE;
      SQ_DIG_RD: begin
        st_d   = SQ_DIG_WR;
        step_d = '0;
      end
      SQ_DIG_WR: begin
        if (step_q == DIG_LAST) st_d = SQ_IDLE;
        else                    step_d = step_q + STEP_ONE;
      end
      SQ_SPILL: begin
        if (last_step) st_d = SQ_IDLE;
        else           step_d = step_q + STEP_ONE;
      end
      SQ_FILL: begin
        if (last_step) st_d = SQ_FILL_TAIL;
        else           step_d = step_q + STEP_ONE;
      end
      SQ_FILL_TAIL: st_d = SQ_IDLE;
      default:      st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (accept) begin
      x_q <= xin;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_ADD, SQ_BAD, SQ_FILL_TAIL: done = 1'b1;
      SQ_DIG_WR:                    done = (step_q == DIG_LAST);
      SQ_SPILL:                     done = last_step;
      default:                      done = 1'b0;
    endcase
  end

  assign busy    = (st_q != SQ_IDLE);
  assign illegal = (st_q == SQ_BAD);
  assign state   = st_q;
  assign step    = step_q;
  assign xreg    = x_q;
endmodule

// File: rtl/idx_xfer_unit.sv
module idx_xfer_unit
  import ixu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [11:0]       instr,
  input  logic              idx_set,
  input  logic [ADDR_W-1:0] idx_set_val,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [ADDR_W-1:0] idx_out,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [RIDX_W-1:0] FLAG_REG = '1;
  localparam int unsigned       DIG_PAD  = DATA_W - 4;
  localparam int unsigned       STEP_PAD = ADDR_W - RIDX_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  sq_state_e         state;
  logic [RIDX_W-1:0] step;
  logic [RIDX_W-1:0] xreg;
  logic              carry;
  logic [3:0]        d_hund, d_tens, d_ones;
  logic [3:0]        dig_q [3];
  logic              dig_en;
  logic [3:0]        dig_sel;

  ixu_seq #(.RIDX_W(RIDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .start   (start),
    .opc     (instr[7:0]),
    .xin     (instr[11:8]),
    .state   (state),
    .step    (step),
    .xreg    (xreg),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  ixu_index_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_q),
    .set_en  (idx_set && !busy),
    .set_val (idx_set_val),
    .add_en  (state == SQ_ADD),
    .add_val (rf_rdata),
    .idx     (idx_out),
    .carry   (carry)
  );

  ixu_digits u_dig (
    .val  (rf_rdata),
    .hund (d_hund),
    .tens (d_tens),
    .ones (d_ones)
  );

  // digit holding registers, captured in the read cycle
  assign dig_en = (state == SQ_DIG_RD);
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dig_q[0] <= '0;
      dig_q[1] <= '0;
      dig_q[2] <= '0;
    end else if (dig_en) begin
      dig_q[0] <= d_hund;
      dig_q[1] <= d_tens;
      dig_q[2] <= d_ones;
    end
  end

  always_comb begin
    unique case (step[1:0])
      2'd0:    dig_sel = dig_q[0];
      2'd1:    dig_sel = dig_q[1];
      default: dig_sel = dig_q[2];
    endcase
  end

  // register-file read port
  always_comb begin
    unique case (state)
      SQ_ADD, SQ_DIG_RD: rf_raddr = xreg;
      SQ_SPILL:          rf_raddr = step;
      default:           rf_raddr = '0;
    endcase
  end

  // memory port
  assign mem_addr  = idx_out + {{STEP_PAD{1'b0}}, step};
  assign mem_we    = (state == SQ_DIG_WR) || (state == SQ_SPILL);
  assign mem_re    = (state == SQ_FILL);
  assign mem_wdata = (state == SQ_DIG_WR) ? {{DIG_PAD{1'b0}}, dig_sel} : rf_rdata;

  // register-file write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = '0;
    rf_wdata = mem_rdata;
    unique case (state)
      SQ_ADD: begin
        rf_we    = 1'b1;
        rf_waddr = FLAG_REG;
        rf_wdata = {{(DATA_W-1){1'b0}}, carry};
      end
      SQ_FILL: begin
        rf_we    = (step != '0);
        rf_waddr = step - RIDX_W'(1);
      end
      SQ_FILL_TAIL: begin
        rf_we    = 1'b1;
        rf_waddr = xreg;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ixu_checker.sv
module ixu_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              mem_we,
  input logic              mem_re,
  input logic              rf_we,
  input logic              idx_set,
  input logic [ADDR_W-1:0] idx_set_val,
  input logic [ADDR_W-1:0] idx_out
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !rf_we && !done)); // R1

  AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !mem_we && !mem_re && !rf_we)); // R9

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R5

  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(idx_out)); // R7

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R10

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && idx_set) |=> (idx_out == $past(idx_set_val))); // R11
endmodule

bind idx_xfer_unit ixu_checker #(.ADDR_W(ADDR_W)) u_ixu_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .busy        (busy),
  .done        (done),
  .illegal     (illegal),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .rf_we       (rf_we),
  .idx_set     (idx_set),
  .idx_set_val (idx_set_val),
  .idx_out     (idx_out)
);

// File: tb/tb_idx_xfer_unit.sv
module tb_idx_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic        idx_set = 1'b0;
  logic [11:0] idx_set_val = '0;
  logic        busy, done, illegal;
  logic [11:0] idx_out;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata;
  logic        rf_we, mem_we, mem_re;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  always #10 clk = ~clk; // 50 MHz

  idx_xfer_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .idx_set(idx_set), .idx_set_val(idx_set_val),
    .busy(busy), .done(done), .illegal(illegal), .idx_out(idx_out),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // environment: register file and memory, with a bench poke port
  logic [7:0]  vr  [16];
  logic [7:0]  mem [4096];
  logic [1:0]  pk_kind = 2'd0;
  logic [11:0] pk_addr = '0;
  logic [7:0]  pk_data = '0;

  assign rf_rdata = vr[rf_raddr];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (pk_kind == 2'd2) mem[pk_addr] <= pk_data;
    mem_rdata <= mem[mem_addr];
    if (rf_we) vr[rf_waddr] <= rf_wdata;
    if (pk_kind == 2'd1) vr[pk_addr[3:0]] <= pk_data;
  end

  // reference model state
  int    m_v [16];
  int    m_mem [4096];
  int    m_i;
  int    exp_mem[$];
  int    exp_rf[$];
  string cur_req = "R1";
  int    total = 0;
  int    bad = 0;
  int    ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of every write against the model's expected stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_mem.size() == 0) chk(1'b0, cur_req, int'({mem_addr, mem_wdata}), -1);
        else begin
          ev = exp_mem.pop_front();
          chk(ev == int'({mem_addr, mem_wdata}), cur_req, int'({mem_addr, mem_wdata}), ev);
        end
      end
      if (rf_we) begin
        if (exp_rf.size() == 0) chk(1'b0, cur_req, int'({rf_waddr, rf_wdata}), -1);
        else begin
          ev = exp_rf.pop_front();
          chk(ev == int'({rf_waddr, rf_wdata}), cur_req, int'({rf_waddr, rf_wdata}), ev);
        end
      end
    end
  end

  task automatic poke_reg(input int r, input int d);
    @(negedge clk);
    pk_kind = 2'd1; pk_addr = 12'(r); pk_data = 8'(d);
    m_v[r] = d & 255;
    @(negedge clk);
    pk_kind = 2'd0;
  endtask

  task automatic set_idx(input int v);
    @(negedge clk);
    idx_set = 1'b1; idx_set_val = 12'(v);
    @(negedge clk);
    idx_set = 1'b0;
    m_i = v & 12'hFFF;
    chk(idx_out == 12'(m_i), "R11", int'(idx_out), m_i);
  endtask

  task automatic run_op(input int ins, input bit noisy, input string req);
    int x, opc, exp_lat, lat, s, a;
    bit exp_ill;
    string idx_req;
    x = (ins >> 8) & 15;
    opc = ins & 255;
    exp_ill = 1'b0;
    cur_req = req;
    idx_req = "R7";
    case (opc)
      8'h1E: begin
        s = m_i + m_v[x];
        exp_rf.push_back((15 << 8) | (s > 4095 ? 1 : 0));
        m_i = s & 12'hFFF;
        m_v[15] = (s > 4095) ? 1 : 0;
        exp_lat = 1;
        idx_req = "R3";
      end
      8'h33: begin
        s = m_v[x];
        exp_mem.push_back((m_i << 8) | (s / 100));
        exp_mem.push_back((((m_i + 1) & 12'hFFF) << 8) | ((s / 10) % 10));
        exp_mem.push_back((((m_i + 2) & 12'hFFF) << 8) | (s % 10));
        m_mem[m_i] = s / 100;
        m_mem[(m_i + 1) & 12'hFFF] = (s / 10) % 10;
        m_mem[(m_i + 2) & 12'hFFF] = s % 10;
        exp_lat = 4;
      end
      8'h55: begin
        for (int k = 0; k <= x; k++) begin
          a = (m_i + k) & 12'hFFF;
          exp_mem.push_back((a << 8) | m_v[k]);
          m_mem[a] = m_v[k];
        end
        exp_lat = x + 1;
      end
      8'h65: begin
        for (int k = 0; k <= x; k++) begin
          a = (m_i + k) & 12'hFFF;
          exp_rf.push_back((k << 8) | m_mem[a]);
          m_v[k] = m_mem[a];
        end
        exp_lat = x + 2;
      end
      default: begin
        exp_ill = 1'b1;
        exp_lat = 1;
        idx_req = "R9";
      end
    endcase
    @(negedge clk);
    start = 1'b1; instr = 12'(ins);
    @(negedge clk);
    if (noisy) begin
      // R10: keep start and a direct load of I asserted during the operation
      instr = 12'h3FF; idx_set = 1'b1; idx_set_val = 12'hABC;
      chk(busy == 1'b1, "R10", int'(busy), 1);
    end else begin
      start = 1'b0;
    end
    lat = 1;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    start = 1'b0; idx_set = 1'b0;
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(illegal == exp_ill, "R2", int'(illegal), int'(exp_ill));
    @(negedge clk);
    chk(busy == 1'b0, "R10", int'(busy), 0);
    chk(exp_mem.size() == 0 && exp_rf.size() == 0, req,
        exp_mem.size() + exp_rf.size(), 0);
    chk(idx_out == 12'(m_i), idx_req, int'(idx_out), m_i);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    m_i = 0;
    for (int k = 0; k < 16; k++) m_v[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && illegal == 0, "R1", int'({busy, done, illegal}), 0);
    chk(mem_we == 0 && mem_re == 0 && rf_we == 0, "R1", int'({mem_we, mem_re, rf_we}), 0);
    chk(idx_out == 12'h000, "R1", int'(idx_out), 0);

    for (int k = 0; k < 16; k++) poke_reg(k, (k * 37 + 11) & 255);
    poke_reg(3, 255);
    poke_reg(4, 0);
    poke_reg(5, 109);

    set_idx(12'h100);
    run_op(12'h11E, 1'b0, "R3");          // add, no carry
    set_idx(12'h200);
    run_op(12'h333, 1'b0, "R4");          // digits of 255
    run_op(12'h433, 1'b0, "R4");          // digits of 0
    run_op(12'h533, 1'b0, "R4");          // digits of 109
    set_idx(12'h300);
    run_op(12'h055, 1'b0, "R5");          // single-register spill
    run_op(12'hF55, 1'b1, "R10");         // full spill with start held (R5)
    set_idx(12'hFFE);
    run_op(12'h333, 1'b0, "R8");          // digit store across 0xFFF
    run_op(12'h355, 1'b0, "R8");          // spill across 0xFFF
    for (int k = 0; k < 4; k++) poke_reg(k, 0);
    run_op(12'h365, 1'b0, "R8");          // fill across 0xFFF
    set_idx(12'h300);
    run_op(12'hF65, 1'b0, "R6");          // full fill
    run_op(12'h065, 1'b0, "R6");          // single-register fill
    poke_reg(2, 8'h20);
    set_idx(12'hFF0);
    run_op(12'h21E, 1'b0, "R8");          // add wraps, carry set (R3)
    run_op(12'hF1E, 1'b0, "R3");          // add with register 15 as operand
    run_op(12'h0FF, 1'b0, "R9");
    run_op(12'h500, 1'b0, "R9");
    run_op(12'h766, 1'b1, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule